// File: doc/BRIEF.md
# Burst Beat Address Generator

The block accepts one address-channel request for an AXI read or write burst and turns it into a sequence of beats. Each beat carries a transfer address, a byte-lane strobe for the data bus, and a flag that marks the final beat. The request holds a start address, a length code, a size code and a burst kind. A mode input chooses between the AXI3 and AXI4 rules for reading the length code. FIXED, INCR and WRAP bursts are supported, and narrow transfers and unaligned starts are handled.

Before it issues anything, the block checks each request. A request is rejected if it breaks a length rule, uses a wrap length that is not allowed, is a wrap that does not start size-aligned, is an INCR burst that crosses a 4KB page, transfers more bytes per beat than the bus carries, or uses the reserved burst kind. A rejected request is consumed and produces a one-cycle error pulse and no beats. A downstream consumer pulls beats with a valid/ready handshake.

Top module: `burstAddrGen`

## Requirements
- R1: A legal request produces exactly (effective length code + 1) beats. `beatLast` is high only on the final beat. After the handshake on the final beat, `beatValid` is low in the next cycle.
- R2: When `axi4Mode` is 0, only `reqLen[3:0]` is used, and bits 7:4 have no effect on the beat count. When it is 1, an INCR burst uses all 8 bits and may carry up to 256 beats.
- R3: When `axi4Mode` is 1, a FIXED or WRAP request with `reqLen[7:4]` nonzero is illegal.
- R4: A WRAP request is legal only with 2, 4, 8 or 16 beats and a start address aligned to the transfer size. Any other WRAP request is illegal.
- R5: The burst kind is encoded as 0 = FIXED, 1 = INCR, 2 = WRAP. In an INCR burst, the first beat carries the start address. Each later beat carries the size-aligned start address plus k times (2^`reqSize`) bytes.
- R6: Every beat of a FIXED burst carries the start address unchanged.
- R7: A WRAP burst starts at the start address and steps by the transfer size. Its addresses stay inside the region of (beats × size) bytes aligned around the start, and they return to the region base when they reach its top.
- R8: An INCR request whose bytes, counted from the size-aligned start, would pass a 4KB boundary is illegal. A burst that ends exactly at the boundary is legal.
- R9: A request is illegal if 2^`reqSize` is larger than `DATA_BYTES`, or if `reqBurst` is 3.
- R10: Strobe bit i is set when i is at or above the start address modulo `DATA_BYTES` and below the end of the size-aligned window that contains that offset.
- R11: `reqReady` is high only while no burst is in progress. An accepted illegal request raises `errFlag` for exactly the next cycle and issues no beat.
- R12: While `beatValid` is high and `beatReady` is low, the address, strobe and last flag stay the same in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted this cycle when high with reqValid |
| reqAddr | input | ADDR_W | Burst start address |
| reqLen | input | 8 | Length code (beats minus one) |
| reqSize | input | 3 | Size code, bytes per beat = 2^code |
| reqBurst | input | 2 | Burst kind: 0 FIXED, 1 INCR, 2 WRAP |
| axi4Mode | input | 1 | 1 selects the AXI4 length rules, 0 the AXI3 rules |
| errFlag | output | 1 | One-cycle pulse after an illegal request is consumed |
| beatValid | output | 1 | A beat is presented |
| beatReady | input | 1 | Consumer takes the beat |
| beatAddr | output | ADDR_W | Beat transfer address |
| beatStrb | output | DATA_BYTES | Beat byte-lane strobes |
| beatLast | output | 1 | Final beat of the burst |

## Verification
The bench builds the block with its defaults: a 32-bit address and an 8-byte bus. With these values, size codes 0 to 3 are legal and 4 to 7 exceed the bus, so the oversize rejection and every narrow lane pattern on an 8-lane bus can be exercised. The 32-bit address lets bursts sit just below and exactly at a 4KB page end. They also allow a full 256-beat INCR burst and 16-beat wraps of 8-byte beats. The consumer's ready is stalled in a pseudo-random pattern, so holds occur on first, middle and last beats.

// File: rtl/burstPkg.sv
package burstPkg;
  typedef enum logic [1:0] {
    BURST_FIXED = 2'd0,
    BURST_INCR  = 2'd1,
    BURST_WRAP  = 2'd2,
    BURST_RSVD  = 2'd3
  } burstKind_e;

  typedef struct packed {
    logic load;
    logic step;
  } ctrlStrobes_t;
endpackage

// File: rtl/burstLegal.sv
module burstLegal
  import burstPkg::*;
#(
  parameter int DATA_BYTES = 8
) (
  input  logic [11:0]  addrLow,
  input  logic [7:0]   reqLen,
  input  logic [2:0]   reqSize,
  input  burstKind_e   reqBurst,
  input  logic         axi4Mode,
  output logic         legal,
  output logic [7:0]   lenEff,
  output logic [15:0]  totalBytes
);
  logic [8:0]  beats;
  logic [7:0]  szBytes;
  logic [12:0] alignedLow;
  logic [16:0] endSum;
  logic sizeOk, lenOk, wrapOk, pageOk, kindOk;

  always_comb begin
    lenEff     = axi4Mode ? reqLen : {4'b0, reqLen[3:0]};
    beats      = {1'b0, lenEff} + 9'd1;
    szBytes    = 8'd1 << reqSize;
    totalBytes = 16'(beats) << reqSize;
    alignedLow = {1'b0, addrLow & ~(12'(szBytes) - 12'd1)};
    endSum     = 17'(alignedLow) + 17'(totalBytes);
    sizeOk = 32'(szBytes) <= 32'(DATA_BYTES);
    lenOk  = !(axi4Mode && reqBurst != BURST_INCR && reqLen[7:4] != 4'd0);
    wrapOk = (reqBurst != BURST_WRAP) ||
             ((lenEff == 8'd1 || lenEff == 8'd3 || lenEff == 8'd7 || lenEff == 8'd15) &&
              (({1'b0, addrLow[6:0]} & (szBytes - 8'd1)) == 8'd0));
    pageOk = (reqBurst != BURST_INCR) || (endSum <= 17'd4096);
    kindOk = reqBurst != BURST_RSVD;
    legal  = sizeOk && lenOk && wrapOk && pageOk && kindOk;
  end
endmodule

// File: rtl/burstCtrl.sv
module burstCtrl
  import burstPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         legal,
  input  logic [7:0]   lenEff,
  input  logic         beatReady,
  output logic         reqReady,
  output logic         beatValid,
  output logic         beatLast,
  output logic         errFlag,
  output ctrlStrobes_t ctrl
);
  logic       busy;
  logic [7:0] remaining;
  logic       accept;

  always_comb begin
    accept    = reqValid && !busy;
    reqReady  = !busy;
    beatValid = busy;
    beatLast  = busy && (remaining == 8'd0);
    ctrl.load = accept && legal;
    ctrl.step = busy && beatReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      remaining <= 8'd0;
      errFlag   <= 1'b0;
    end else begin
      errFlag <= accept && !legal;
      if (ctrl.load) begin
        busy      <= 1'b1;
        remaining <= lenEff;
      end else if (ctrl.step) begin
        if (remaining == 8'd0) busy <= 1'b0;
        else remaining <= remaining - 8'd1;
      end
    end
  end

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> !beatValid); // R11
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    beatValid && !beatReady |=> beatValid && $stable(remaining)); // R12
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    beatValid && beatReady && beatLast |=> !beatValid); // R1
endmodule

// File: rtl/burstDatapath.sv
module burstDatapath
  import burstPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobes_t          ctrl,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [2:0]            reqSize,
  input  burstKind_e            reqBurst,
  input  logic [15:0]           totalBytes,
  output logic [ADDR_W-1:0]     beatAddr,
  output logic [DATA_BYTES-1:0] beatStrb
);
  localparam int LANE_W = $clog2(DATA_BYTES);

  logic [ADDR_W-1:0] curAddr, wrapMask, szA, alignedAddr, incAddr, wrapAddr;
  logic [2:0]        sizeReg;
  burstKind_e        burstReg;
  logic [LANE_W-1:0] laneOff, laneBase;
  logic [LANE_W:0]   szLane, windowEnd;

  always_comb begin
    szA         = ADDR_W'(1) << sizeReg;
    alignedAddr = curAddr & ~(szA - ADDR_W'(1));
    incAddr     = alignedAddr + szA;
    wrapAddr    = (alignedAddr & ~wrapMask) | (incAddr & wrapMask);
    szLane      = (LANE_W+1)'(1) << sizeReg;
    laneOff     = curAddr[LANE_W-1:0];
    laneBase    = laneOff & ~(szLane[LANE_W-1:0] - LANE_W'(1));
    windowEnd   = {1'b0, laneBase} + szLane;
    beatAddr    = curAddr;
  end

  for (genvar i = 0; i < DATA_BYTES; i++) begin : gLane
    localparam logic [LANE_W:0] IDX = (LANE_W+1)'(i);
    assign beatStrb[i] = ({1'b0, laneOff} <= IDX) && (IDX < windowEnd);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr  <= '0;
      wrapMask <= '0;
      sizeReg  <= 3'd0;
      burstReg <= BURST_FIXED;
    end else if (ctrl.load) begin
      curAddr  <= reqAddr;
      wrapMask <= ADDR_W'(totalBytes) - ADDR_W'(1);
      sizeReg  <= reqSize;
      burstReg <= reqBurst;
    end else if (ctrl.step) begin
      case (burstReg)
        BURST_INCR: curAddr <= incAddr;
        BURST_WRAP: curAddr <= wrapAddr;
        default:    curAddr <= curAddr;
      endcase
    end
  end

  AST_FIXED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.step && !ctrl.load && burstReg == BURST_FIXED |=> $stable(curAddr)); // R6
  AST_WRAP_REGION: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.step && !ctrl.load && burstReg == BURST_WRAP |=>
      ((curAddr & ~wrapMask) == ($past(curAddr) & ~wrapMask))); // R7
endmodule

// File: rtl/burstAddrGen.sv
module burstAddrGen
  import burstPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [7:0]            reqLen,
  input  logic [2:0]            reqSize,
  input  logic [1:0]            reqBurst,
  input  logic                  axi4Mode,
  output logic                  errFlag,
  output logic                  beatValid,
  input  logic                  beatReady,
  output logic [ADDR_W-1:0]     beatAddr,
  output logic [DATA_BYTES-1:0] beatStrb,
  output logic                  beatLast
);
  ctrlStrobes_t ctrl;
  logic         legal;
  logic [7:0]   lenEff;
  logic [15:0]  totalBytes;
  burstKind_e   burstKind;

  assign burstKind = burstKind_e'(reqBurst);

  burstLegal #(.DATA_BYTES(DATA_BYTES)) uLegal (
    .addrLow(reqAddr[11:0]), .reqLen(reqLen), .reqSize(reqSize),
    .reqBurst(burstKind), .axi4Mode(axi4Mode),
    .legal(legal), .lenEff(lenEff), .totalBytes(totalBytes)
  );

  burstCtrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .legal(legal),
    .lenEff(lenEff), .beatReady(beatReady), .reqReady(reqReady),
    .beatValid(beatValid), .beatLast(beatLast), .errFlag(errFlag),
    .ctrl(ctrl)
  );

  burstDatapath #(.ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES)) uPath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqBurst(burstKind), .totalBytes(totalBytes),
    .beatAddr(beatAddr), .beatStrb(beatStrb)
  );

  AST_PAGE_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    beatValid && beatReady && !beatLast |=>
      beatAddr[ADDR_W-1:12] == $past(beatAddr[ADDR_W-1:12])); // R8
  AST_STRB_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    beatValid |-> beatStrb != '0); // R10
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    beatValid && !beatReady |=>
      $stable(beatAddr) && $stable(beatStrb) && $stable(beatLast)); // R12
  AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    beatValid |-> !reqReady); // R11
endmodule

// File: tb/burstAddrGen_test.sv
module burstAddrGen_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DB = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, axi4Mode = 1'b0, beatReady = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [7:0] reqLen = '0;
  logic [2:0] reqSize = '0;
  logic [1:0] reqBurst = '0;
  logic reqReady, errFlag, beatValid, beatLast;
  logic [AW-1:0] beatAddr;
  logic [DB-1:0] beatStrb;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burstAddrGen #(.ADDR_W(AW), .DATA_BYTES(DB)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqSize(reqSize), .reqBurst(reqBurst),
    .axi4Mode(axi4Mode), .errFlag(errFlag), .beatValid(beatValid),
    .beatReady(beatReady), .beatAddr(beatAddr), .beatStrb(beatStrb),
    .beatLast(beatLast)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic runReq(input string tag, input bit a4, input int unsigned addr,
                        input int len, input int size, input int kind);
    int beats, sz, total, alignedLow, base, k;
    bit ok;
    int unsigned expAddr[$];
    int expStrb[$];
    beats = a4 ? len + 1 : (len % 16) + 1;
    sz = 1 << size;
    ok = (sz <= DB) && (kind != 3);
    if (a4 && kind != 1 && len > 15) ok = 0;
    if (kind == 2 && !(beats == 2 || beats == 4 || beats == 8 || beats == 16)) ok = 0;
    if (kind == 2 && (addr % sz) != 0) ok = 0;
    alignedLow = int'(addr % 4096) - int'(addr % 4096) % sz;
    if (kind == 1 && alignedLow + beats * sz > 4096) ok = 0;
    total = beats * sz;
    base = int'(addr) - int'(addr % total);
    for (int b = 0; b < beats; b++) begin
      int unsigned a;
      int off, lb, m;
      if (kind == 0) a = addr;
      else if (kind == 1) a = (b == 0) ? addr : (addr - addr % sz) + b * sz;
      else a = base + ((int'(addr) - base + b * sz) % total);
      off = int'(a % DB);
      lb = off - off % sz;
      m = 0;
      for (int i = off; i < lb + sz; i++) m |= (1 << i);
      expAddr.push_back(a);
      expStrb.push_back(m);
    end
    @(negedge clk);
    check(reqReady == 1'b1, "R11", "reqReady idle", reqReady, 1);
    axi4Mode = a4; reqAddr = addr; reqLen = len[7:0];
    reqSize = size[2:0]; reqBurst = kind[1:0]; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    if (!ok) begin
      check(errFlag == 1'b1, tag, "errFlag on illegal", errFlag, 1);
      check(beatValid == 1'b0, tag, "no beat on illegal", beatValid, 0);
      @(negedge clk);
      check(errFlag == 1'b0, "R11", "errFlag one cycle", errFlag, 0);
      check(beatValid == 1'b0, "R11", "still no beat", beatValid, 0);
    end else begin
      check(errFlag == 1'b0, tag, "errFlag on legal", errFlag, 0);
      k = 0;
      while (k < beats) begin
        beatReady = ($urandom_range(0, 3) != 0);
        check(beatValid == 1'b1, tag, "beatValid", beatValid, 1);
        check(beatAddr == expAddr[k], tag, "beatAddr", beatAddr, expAddr[k]);
        check(int'(beatStrb) == expStrb[k], tag, "beatStrb", beatStrb, expStrb[k]);
        check(beatLast == (k == beats - 1), "R1", "beatLast", beatLast, k == beats - 1);
        check(reqReady == 1'b0, "R11", "reqReady busy", reqReady, 0);
        if (!beatReady) check(1'b1, "R12", "stall", 0, 0);
        @(negedge clk);
        if (beatReady) k++;
      end
      beatReady = 1'b0;
      check(beatValid == 1'b0, "R1", "burst ended", beatValid, 0);
      check(reqReady == 1'b1, "R11", "ready after burst", reqReady, 1);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(beatValid == 1'b0, "R11", "reset beatValid", beatValid, 0);
    check(errFlag == 1'b0, "R11", "reset errFlag", errFlag, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R11", "reset reqReady", reqReady, 1);

    runReq("R5", 1, 32'h100, 3, 3, 1);      // aligned INCR
    runReq("R10", 1, 32'h103, 4, 2, 1);     // unaligned narrow INCR
    runReq("R2", 1, 32'h2000, 255, 0, 1);   // 256 beats in AXI4 mode
    runReq("R2", 0, 32'h400, 8'hF3, 3, 1);  // AXI3 ignores top bits
    runReq("R6", 1, 32'h45, 2, 1, 0);       // FIXED narrow
    runReq("R7", 1, 32'h38, 3, 2, 2);       // WRAP 4 beats
    runReq("R7", 1, 32'h1F8, 15, 3, 2);     // WRAP 16 beats
    runReq("R4", 1, 32'h40, 2, 2, 2);       // WRAP 3 beats illegal
    runReq("R4", 1, 32'h39, 3, 2, 2);       // WRAP unaligned illegal
    runReq("R3", 1, 32'h80, 16, 2, 0);      // AXI4 FIXED 17 beats illegal
    runReq("R3", 1, 32'h80, 17, 1, 2);      // AXI4 WRAP long illegal
    runReq("R2", 0, 32'h80, 8'h10, 2, 0);   // AXI3 FIXED, one beat
    runReq("R2", 0, 32'h60, 8'h13, 2, 2);   // AXI3 WRAP, four beats
    runReq("R8", 1, 32'hFF8, 1, 3, 1);      // crosses page
    runReq("R8", 1, 32'h1FF0, 1, 3, 1);     // ends at page edge
    runReq("R8", 1, 32'h3F01, 254, 0, 1);   // 255 bytes to page edge
    runReq("R9", 1, 32'h0, 0, 4, 1);        // size over bus
    runReq("R9", 1, 32'h0, 1, 2, 3);        // reserved kind
    runReq("R10", 1, 32'h7, 0, 0, 1);       // single top lane
    runReq("R10", 1, 32'h106, 1, 2, 0);     // FIXED unaligned narrow

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule